// File: doc/BRIEF.md
# System Clock Loss Monitor

This block watches a system clock from a separate, free-running reference clock and raises a reset request when the system clock stops. Each rising edge of the system clock flips a toggle flop. The toggle crosses into the reference domain through a short synchronizer chain, and every change it shows there restarts a quiet-time counter. If the counter reaches the timeout window before the next change arrives, the block asserts its reset request. The request stays high until the system clock runs again or the monitor is disabled.

The timeout window is given in picoseconds together with the reference clock period. The block derives the cycle limit at elaboration by dividing the window by the period and rounding up. For a 100 µs window on a 250 MHz reference, the limit is 25000 cycles. The request drives the chip's reset controller and is the block's only output. Any external reset pin is neither driven nor sensed here. The enable input is sampled on the reference clock.

Top module: `clk_loss_monitor`

## Requirements
- R1: While `rst_n` is low, `clk_loss_req` is low. Reset acts asynchronously, and it clears a request that is already asserted.
- R2: While enabled, a system clock that keeps running never causes `clk_loss_req` to go high. This holds for system clock periods of at least 1.5 reference periods.
- R3: After the last system clock rising edge, `clk_loss_req` stays low for at least LIMIT−2 reference cycles. It is high by LIMIT+5 cycles, whether the clock stopped high or low.
- R4: Once asserted, `clk_loss_req` stays high for as long as the system clock stays stopped and `mon_enable` stays high.
- R5: When the system clock restarts, `clk_loss_req` returns low within 12 reference cycles of the restart.
- R6: While `mon_enable` is low (the enable is active high), `clk_loss_req` is low from the first reference edge that samples it low, even if the system clock is stopped.
- R7: When `mon_enable` rises with the system clock already stopped, the full window is counted from that point. The request stays low through LIMIT−1 reference edges and is high after LIMIT+1.
- R8: LIMIT equals WINDOW_PS divided by REF_PERIOD_PS, rounded up to the next whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Monitored system clock |
| ref_clk | input | 1 | Independent reference clock that runs the timer |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| mon_enable | input | 1 | Active-high monitor enable, sampled on `ref_clk` |
| clk_loss_req | output | 1 | Active-high reset request, held while the clock is missing |

## Verification
On every reference cycle, the assertions compare the request against an independent count of quiet cycles. This shows that the request never rises early and always rises once the count reaches the limit. The assertions also check that the request holds while the clock stays quiet, and that it drops after observed activity, after disable and during reset. The bench scenarios cover what the assertions do not see: the full path from real `sys_clk` edges through the synchronizer, a clock stopped at either level, restarts, late enables, and the rounded-up limit.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

  // Whole number of reference cycles that cover a window (ceiling division).
  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  // Bits needed to hold values 0..limit.
  function automatic int unsigned count_width(input int unsigned limit);
    int unsigned w;
    w = $clog2(limit + 1);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/clkmon_toggle.sv
module clkmon_toggle (
  input  logic clk,
  input  logic rst_n,
  output logic tgl
);
  // Flips on every monitored rising edge; the level change carries activity.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgl <= 1'b0;
    else        tgl <= ~tgl;
  end
endmodule

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= d;
        else             chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clkmon_change_det.sv
module clkmon_change_det (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic changed
);
  logic d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) d_q <= 1'b0;
    else        d_q <= d;
  end

  assign changed = d ^ d_q;
endmodule

// File: rtl/clkmon_timer.sv
module clkmon_timer #(
  parameter int unsigned LIMIT = 2,
  parameter int unsigned CNT_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic restart,
  output logic expire_evt,
  output logic req
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             req_q;

  assign expire_evt = en && !restart && !req_q && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else if (!en || restart) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else if (!req_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (expire_evt) req_q <= 1'b1;
    end
  end

  assign req = req_q;
endmodule

// File: rtl/clk_loss_monitor.sv
module clk_loss_monitor #(
  parameter int unsigned REF_PERIOD_PS = 4000,
  parameter int unsigned WINDOW_PS     = 100_000_000,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic sys_clk,
  input  logic ref_clk,
  input  logic rst_n,
  input  logic mon_enable,
  output logic clk_loss_req
);
  import clkmon_pkg::*;

  localparam int unsigned LIMIT = ceil_div(WINDOW_PS, REF_PERIOD_PS);
  localparam int unsigned CNT_W = count_width(LIMIT);

  // Named internal events, visible to the bound checker.
  logic sys_tgl;
  logic ref_tgl;
  logic sys_activity;
  logic expire_evt;

  clkmon_toggle u_toggle (
    .clk   (sys_clk),
    .rst_n (rst_n),
    .tgl   (sys_tgl)
  );

  clkmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .d     (sys_tgl),
    .q     (ref_tgl)
  );

  clkmon_change_det u_det (
    .clk     (ref_clk),
    .rst_n   (rst_n),
    .d       (ref_tgl),
    .changed (sys_activity)
  );

  clkmon_timer #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_timer (
    .clk        (ref_clk),
    .rst_n      (rst_n),
    .en         (mon_enable),
    .restart    (sys_activity),
    .expire_evt (expire_evt),
    .req        (clk_loss_req)
  );
endmodule

// File: rtl/clkmon_checker.sv
module clkmon_checker #(
  parameter int unsigned LIMIT = 2
) (
  input logic ref_clk,
  input logic rst_n,
  input logic en,
  input logic act,
  input logic req
);
  localparam int unsigned QW = $clog2(LIMIT + 1) + 1;

  // Independent count of consecutive quiet, enabled reference cycles.
  logic [QW-1:0] quiet;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)                 quiet <= '0;
    else if (!en || act)        quiet <= '0;
    else if (quiet < QW'(LIMIT)) quiet <= quiet + QW'(1);
  end

  a_r1_reset_quiet: assert property (@(posedge ref_clk) !rst_n |-> !req);

  a_r3_not_early: assert property (@(posedge ref_clk) disable iff (!rst_n)
    req |-> (quiet >= QW'(LIMIT)));

  a_r3_fires: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (quiet >= QW'(LIMIT)) |-> req);

  a_r4_holds: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (req && en && !act) |=> req);

  a_r5_activity_clears: assert property (@(posedge ref_clk) disable iff (!rst_n)
    act |=> !req);

  a_r6_disable_clears: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !en |=> !req);
endmodule

bind clk_loss_monitor clkmon_checker #(.LIMIT(LIMIT)) u_chk (
  .ref_clk (ref_clk),
  .rst_n   (rst_n),
  .en      (mon_enable),
  .act     (sys_activity),
  .req     (clk_loss_req)
);

// File: tb/clk_loss_monitor_tb.sv
`timescale 1ns/1ps
module clk_loss_monitor_tb;
  localparam int unsigned REF_PS  = 4000;
  localparam int unsigned WIN_PS  = 398_500;
  localparam int unsigned NSYNC   = 2;

  logic ref_clk = 1'b0;
  logic sys_clk = 1'b0;
  logic rst_n = 1'b0;
  logic mon_enable = 1'b0;
  logic clk_loss_req;
  logic sys_run = 1'b0;
  int   sys_half = 10;
  int   checks = 0;
  int   bad = 0;
  int   lim = 0;
  bit   done = 1'b0;

  clk_loss_monitor #(.REF_PERIOD_PS(REF_PS), .WINDOW_PS(WIN_PS), .SYNC_STAGES(NSYNC)) u_dut (
    .sys_clk      (sys_clk),
    .ref_clk      (ref_clk),
    .rst_n        (rst_n),
    .mon_enable   (mon_enable),
    .clk_loss_req (clk_loss_req)
  );

  always #2 ref_clk = ~ref_clk;  // 250 MHz

  initial forever begin
    if (sys_run) begin
      #(sys_half);
      if (sys_run) sys_clk = ~sys_clk;
    end else @(posedge sys_run);
  end

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: clk_loss_req=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic ref_wait(input int n);
    repeat (n) @(posedge ref_clk);
    #1;
  endtask

  task automatic stop_sys(input logic lvl);
    do @(sys_clk); while (sys_clk !== lvl);
    sys_run = 1'b0;
  endtask

  task automatic t_reset();
    sys_run = 1'b1;
    mon_enable = 1'b1;
    ref_wait(3);
    check("R1 during reset", clk_loss_req, 1'b0);
    rst_n = 1'b1;
    ref_wait(2);
    check("R1 after release", clk_loss_req, 1'b0);
  endtask

  task automatic t_running(input int half);
    logic seen;
    sys_half = half;
    seen = 1'b0;
    for (int i = 0; i < 3 * lim; i++) begin
      ref_wait(1);
      if (clk_loss_req !== 1'b0) seen = 1'b1;
    end
    check("R2 running clock", seen, 1'b0);
  endtask

  task automatic t_stop(input logic lvl);
    sys_half = 10;
    stop_sys(lvl);
    ref_wait(lim - 2);
    check("R3 not before window", clk_loss_req, 1'b0);
    ref_wait(7);
    check("R3 fires after window", clk_loss_req, 1'b1);
    ref_wait(2 * lim);
    check("R4 held while stopped", clk_loss_req, 1'b1);
  endtask

  task automatic t_resume();
    sys_run = 1'b1;
    ref_wait(12);
    check("R5 cleared on restart", clk_loss_req, 1'b0);
    ref_wait(2 * lim);
    check("R5 stays clear", clk_loss_req, 1'b0);
  endtask

  task automatic t_disable();
    stop_sys(1'b0);
    ref_wait(lim + 6);
    check("R3 fires before disable", clk_loss_req, 1'b1);
    mon_enable = 1'b0;
    ref_wait(1);
    check("R6 drops on disable", clk_loss_req, 1'b0);
    ref_wait(3 * lim);
    check("R6 quiet while disabled", clk_loss_req, 1'b0);
  endtask

  task automatic t_late_enable();
    mon_enable = 1'b1;
    ref_wait(lim - 1);
    check("R7 full window after enable", clk_loss_req, 1'b0);
    ref_wait(2);
    check("R7 fires after enable window", clk_loss_req, 1'b1);
  endtask

  task automatic t_reset_mid();
    rst_n = 1'b0;
    #1;
    check("R1 async clear", clk_loss_req, 1'b0);
    ref_wait(2);
    rst_n = 1'b1;
    ref_wait(lim - 3);
    check("R8 rounded limit, not early", clk_loss_req, 1'b0);
    ref_wait(5);
    check("R8 rounded limit, fired", clk_loss_req, 1'b1);
    sys_run = 1'b1;
    ref_wait(12);
    check("R5 restart after reset", clk_loss_req, 1'b0);
  endtask

  initial begin
    lim = 0;
    while (lim * REF_PS < WIN_PS) lim++;   // R8: ceiling of window over period
    t_reset();
    t_running(10);
    t_running(5);
    t_stop(1'b1);
    t_resume();
    t_stop(1'b0);
    t_resume();
    t_disable();
    t_late_enable();
    t_reset_mid();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #400_000;
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog: run did not complete, got=hung expected=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule